// File: doc/BRIEF.md
# Conversion Result Register Bank

This block stores the latest result for each of fourteen conversion slots of a 12-bit converter. Twelve slots hold the external channels 0 to 11. Slot 12 holds the band-gap reference and slot 13 holds the temperature sensor. The conversion engine hands over one result at a time as a slot index and a raw 12-bit code. The bank widens the code to a 16-bit field, either zero-filled or sign-extended. Each slot keeps its own flag for unread data and its own flag for data that was overwritten.

Software reads the bank through a plain read port, and reading a slot consumes its flags. Two more addresses return a status word and the word last handed to the DMA side. The status word collects the flags of every slot. When DMA mode is on, every accepted result also raises a one-cycle transfer request and refreshes the DMA mirror.

The load side is a valid/ready stream. Ready is tied high, so the bank never applies back-pressure. The engine may present one result in every cycle, and each cycle with valid high transfers exactly one result.

Top module: `adc_result_bank`

## Requirements
- R1: With `fmt_signed` low, a slot word holds the code in bits 11:0 and zeros in bits 15:12.
- R2: With `fmt_signed` high, a slot word holds the code in bits 11:0 and copies code bit 11 into bits 15:12.
- R3: A load with `ld_valid` high and `ld_chan` below 14 stores the field into that slot. From the next cycle the slot's valid flag (word bit 17) is set. `ld_ready` is always high.
- R4: A load into a slot whose valid flag is still set replaces the old field and sets the slot's overrun flag (word bit 16).
- R5: When `rd_en` is high with `rd_addr` 0 to 13, the slot word is returned on `rd_data` in the next cycle with `rd_valid` high. At that same edge, the slot's valid and overrun flags clear.
- R6: When a load and a read hit the same slot in one cycle, the read returns the old word and the load wins. Valid stays set, and overrun takes the slot's valid flag from before that cycle.
- R7: `status_o` carries the valid flags of slots 0 to 13 in bits 13:0 and their overrun flags in bits 29:16. A read at `rd_addr` 14 returns this word and clears no flag.
- R8: When `dma_en` is high, each accepted load pulses `dma_req` for exactly one cycle, in the cycle after the load. In that same cycle `dma_data` takes the 18-bit slot word just written. A read at `rd_addr` 15 returns `dma_data`.
- R9: When `dma_en` is low, no request is raised and `dma_data` holds its value.
- R10: A load with `ld_chan` 14 or 15 is dropped: no flag, slot or DMA output changes.
- R11: After reset, every slot, flag, `rd_data`, `rd_valid`, `dma_req` and `dma_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_signed | input | 1 | 1 selects sign extension of the code |
| dma_en | input | 1 | Enables DMA requests and the mirror update |
| ld_valid | input | 1 | Result present on the load stream |
| ld_ready | output | 1 | Always 1; the stream is never stalled |
| ld_chan | input | 4 | Slot index of the result |
| ld_code | input | 12 | Raw conversion code |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | 0-13 slot, 14 status, 15 DMA mirror |
| rd_valid | output | 1 | rd_data holds a read result |
| rd_data | output | 32 | Registered read data |
| status_o | output | 32 | Live flag summary word |
| dma_req | output | 1 | One-cycle transfer request |
| dma_data | output | 18 | Word of the last DMA-enabled load |

## Verification
The properties assume that every input is driven synchronously to `clk` and holds a defined value once reset is released. They also assume that `ld_chan` and `rd_addr` may take any 4-bit value, including the two slot indexes that do not exist. The bench changes all inputs only on falling edges and never leaves a strobe or an index undefined. It also drives the out-of-range slot indexes, so the guards in the properties are exercised and not just assumed.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;
  // classes of read address
  typedef enum logic [1:0] {
    RK_SLOT   = 2'd0,
    RK_STATUS = 2'd1,
    RK_DMA    = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/adc_rb_fmt.sv
module adc_rb_fmt #(
  parameter int CODE_W  = 12,
  parameter int FIELD_W = 16
) (
  input  logic [CODE_W-1:0]  code,
  input  logic               fmt_signed,
  output logic [FIELD_W-1:0] field
);
  localparam int PAD_W = FIELD_W - CODE_W;
  logic pad_bit;
  assign pad_bit = fmt_signed & code[CODE_W-1];
  assign field   = {{PAD_W{pad_bit}}, code};
endmodule

// File: rtl/adc_rb_slot.sv
module adc_rb_slot #(
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               rd_clr,
  input  logic [FIELD_W-1:0] field_in,
  output logic [FIELD_W-1:0] field_q,
  output logic               valid_q,
  output logic               ovr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (load) begin
      // a load beats a same-cycle read
      field_q <= field_in;
      valid_q <= 1'b1;
      ovr_q   <= valid_q;
    end else if (rd_clr) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_rb_dma.sv
module adc_rb_dma #(
  parameter int ENTRY_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [ENTRY_W-1:0] entry_in,
  output logic               req,
  output logic [ENTRY_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req  <= 1'b0;
      data <= '0;
    end else begin
      req <= fire;
      if (fire) data <= entry_in;
    end
  end
endmodule

// File: rtl/adc_rb_rdmux.sv
module adc_rb_rdmux
  import adc_rb_pkg::*;
#(
  parameter int NSLOT   = 14,
  parameter int FIELD_W = 16,
  parameter int CH_W    = 4,
  parameter int WORD_W  = 32,
  parameter int ENTRY_W = FIELD_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [CH_W-1:0]          rd_addr,
  input  logic [NSLOT*FIELD_W-1:0] fields,
  input  logic [NSLOT-1:0]         valid_vec,
  input  logic [NSLOT-1:0]         ovr_vec,
  input  logic [WORD_W-1:0]        status,
  input  logic [ENTRY_W-1:0]       dma_word,
  output logic                     rd_valid,
  output logic [WORD_W-1:0]        rd_data
);
  localparam int HI_PAD = WORD_W - ENTRY_W;
  localparam logic [CH_W-1:0] A_STATUS = CH_W'(NSLOT);
  localparam logic [CH_W-1:0] A_DMA    = CH_W'(NSLOT + 1);

  rd_kind_e          kind;
  logic [ENTRY_W-1:0] slot_word;
  logic [WORD_W-1:0]  next_word;

  always_comb begin
    if (rd_addr == A_STATUS)      kind = RK_STATUS;
    else if (rd_addr == A_DMA)    kind = RK_DMA;
    else                          kind = RK_SLOT;
  end

  always_comb begin
    slot_word = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (rd_addr == CH_W'(k))
        slot_word = {valid_vec[k], ovr_vec[k], fields[k*FIELD_W +: FIELD_W]};
    end
  end

  always_comb begin
    unique case (kind)
      RK_STATUS: next_word = status;
      RK_DMA:    next_word = {{HI_PAD{1'b0}}, dma_word};
      default:   next_word = {{HI_PAD{1'b0}}, slot_word};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= next_word;
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int CODE_W  = 12,
  parameter int FIELD_W = 16,
  parameter int NSLOT   = 14,
  localparam int CH_W   = $clog2(NSLOT + 2),
  localparam int ENTRY_W = FIELD_W + 2,
  localparam int WORD_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fmt_signed,
  input  logic               dma_en,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [CH_W-1:0]    ld_chan,
  input  logic [CODE_W-1:0]  ld_code,
  input  logic               rd_en,
  input  logic [CH_W-1:0]    rd_addr,
  output logic               rd_valid,
  output logic [WORD_W-1:0]  rd_data,
  output logic [WORD_W-1:0]  status_o,
  output logic               dma_req,
  output logic [ENTRY_W-1:0] dma_data
);
  localparam int OVR_LSB = WORD_W / 2;

  logic [FIELD_W-1:0]       new_field;
  logic [NSLOT-1:0]         load_vec;
  logic [NSLOT-1:0]         clr_vec;
  logic [NSLOT-1:0]         valid_vec;
  logic [NSLOT-1:0]         ovr_vec;
  logic [NSLOT*FIELD_W-1:0] fields;
  logic                     chan_ok;
  logic                     hit_valid;
  logic                     dma_fire;

  assign ld_ready = 1'b1;
  assign chan_ok  = (ld_chan < CH_W'(NSLOT));

  adc_rb_fmt #(.CODE_W(CODE_W), .FIELD_W(FIELD_W)) fmt_i (
    .code(ld_code), .fmt_signed(fmt_signed), .field(new_field)
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign load_vec[k] = ld_valid && ld_ready && (ld_chan == CH_W'(k));
    assign clr_vec[k]  = rd_en && (rd_addr == CH_W'(k));
    adc_rb_slot #(.FIELD_W(FIELD_W)) slot_i (
      .clk(clk), .rst_n(rst_n),
      .load(load_vec[k]), .rd_clr(clr_vec[k]),
      .field_in(new_field),
      .field_q(fields[k*FIELD_W +: FIELD_W]),
      .valid_q(valid_vec[k]), .ovr_q(ovr_vec[k])
    );
  end

  always_comb begin
    hit_valid = 1'b0;
    for (int k = 0; k < NSLOT; k++)
      if (load_vec[k]) hit_valid = valid_vec[k];
  end

  always_comb begin
    status_o = '0;
    status_o[NSLOT-1:0]        = valid_vec;
    status_o[OVR_LSB +: NSLOT] = ovr_vec;
  end

  assign dma_fire = ld_valid && ld_ready && chan_ok && dma_en;

  adc_rb_dma #(.ENTRY_W(ENTRY_W)) dma_i (
    .clk(clk), .rst_n(rst_n), .fire(dma_fire),
    .entry_in({1'b1, hit_valid, new_field}),
    .req(dma_req), .data(dma_data)
  );

  adc_rb_rdmux #(
    .NSLOT(NSLOT), .FIELD_W(FIELD_W), .CH_W(CH_W),
    .WORD_W(WORD_W), .ENTRY_W(ENTRY_W)
  ) rdmux_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .fields(fields), .valid_vec(valid_vec), .ovr_vec(ovr_vec),
    .status(status_o), .dma_word(dma_data),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk #(
  parameter int NSLOT = 14,
  parameter int CH_W  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ld_valid,
  input logic [CH_W-1:0] ld_chan,
  input logic            dma_en,
  input logic            rd_en,
  input logic [CH_W-1:0] rd_addr,
  input logic            rd_valid,
  input logic [31:0]     status_o,
  input logic            dma_req
);
  localparam int OVR_LSB = 16;

  // R3: an in-range load leaves that slot valid
  assert_load_sets_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_chan < CH_W'(NSLOT)) |=> status_o[$past(ld_chan)]);

  // R4: overrun never stands without valid
  assert_ovr_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o[OVR_LSB +: NSLOT] & ~status_o[NSLOT-1:0]) == '0));

  // R5: a slot read without a competing load consumes both flags
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr < CH_W'(NSLOT) && !(ld_valid && ld_chan == rd_addr))
    |=> (!status_o[$past(rd_addr)] && !status_o[OVR_LSB + int'($past(rd_addr))]));

  // R5: read data follows the strobe by one cycle
  assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R7: status read with no load leaves flags untouched
  assert_status_read_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == CH_W'(NSLOT) && !ld_valid) |=> $stable(status_o));

  // R8: enabled in-range load requests a transfer
  assert_dma_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && dma_en && ld_chan < CH_W'(NSLOT)) |=> dma_req);

  // R9 / R10: no request without an enabled in-range load
  assert_no_spurious_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_valid && dma_en && ld_chan < CH_W'(NSLOT)) |=> !dma_req);
endmodule

bind adc_result_bank adc_result_bank_chk #(.NSLOT(NSLOT), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_chan(ld_chan),
  .dma_en(dma_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .status_o(status_o), .dma_req(dma_req)
);

// File: tb/adc_result_bank_tb_top.sv
module adc_result_bank_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 6;
  // {chan[4], signed[1], code[12], expected word[32]}
  localparam logic [48:0] VEC [NV] = '{
    {4'd0,  1'b0, 12'hABC, 32'h0002_0ABC},
    {4'd3,  1'b1, 12'h800, 32'h0002_F800},
    {4'd5,  1'b1, 12'h7FF, 32'h0002_07FF},
    {4'd12, 1'b0, 12'hFFF, 32'h0002_0FFF},
    {4'd13, 1'b1, 12'h9A5, 32'h0002_F9A5},
    {4'd11, 1'b1, 12'h001, 32'h0002_0001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_signed = 1'b0, dma_en = 1'b0, ld_valid = 1'b0, rd_en = 1'b0;
  logic [3:0]  ld_chan = '0, rd_addr = '0;
  logic [11:0] ld_code = '0;
  logic        ld_ready, rd_valid, dma_req;
  logic [31:0] rd_data, status_o;
  logic [17:0] dma_data;
  int checks = 0, fails = 0;
  logic [31:0] w;

  always #(CLK_P/2) clk = ~clk;

  adc_result_bank dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_signed(fmt_signed), .dma_en(dma_en),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_chan(ld_chan), .ld_code(ld_code),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .status_o(status_o), .dma_req(dma_req), .dma_data(dma_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(logic [3:0] ch, logic [11:0] code, logic sgn);
    @(negedge clk);
    ld_valid = 1'b1; ld_chan = ch; ld_code = code; fmt_signed = sgn;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R5 rd_valid", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  task automatic load_and_read(logic [3:0] ch, logic [11:0] code, output logic [31:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_chan = ch; ld_code = code; fmt_signed = 1'b0;
    rd_en = 1'b1; rd_addr = ch;
    @(negedge clk);
    ld_valid = 1'b0; rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 status", status_o, 32'h0);
    chk("R11 rd_data", rd_data, 32'h0);
    chk("R11 rd_valid", {31'd0, rd_valid}, 32'h0);
    chk("R11 dma_req", {31'd0, dma_req}, 32'h0);
    chk("R11 dma_data", {14'd0, dma_data}, 32'h0);
    rst_n = 1'b1;
    chk("R3 ld_ready", {31'd0, ld_ready}, 32'h1);

    // R1 R2 R3 R5: table walk
    for (int i = 0; i < NV; i++) begin
      load(VEC[i][48:45], VEC[i][43:32], VEC[i][44]);
      chk("R3 valid in status", {31'd0, status_o[VEC[i][48:45]]}, 32'h1);
      rd(VEC[i][48:45], w);
      chk(VEC[i][44] ? "R2 signed word" : "R1 unsigned word", w, VEC[i][31:0]);
    end
    chk("R5 flags consumed", status_o, 32'h0);

    // R4 overrun then R5 clear
    load(4'd2, 12'h111, 1'b0);
    load(4'd2, 12'h222, 1'b0);
    chk("R4 status ovr", status_o, 32'h0004_0004);
    rd(4'd2, w);
    chk("R4 overwritten word", w, 32'h0003_0222);
    rd(4'd2, w);
    chk("R5 reread cleared", w, 32'h0000_0222);

    // R7 status mirror
    load(4'd1, 12'h010, 1'b0);
    load(4'd4, 12'h020, 1'b0);
    load(4'd4, 12'h030, 1'b0);
    chk("R7 status_o", status_o, 32'h0010_0012);
    rd(4'd14, w);
    chk("R7 status read", w, 32'h0010_0012);
    rd(4'd14, w);
    chk("R7 status not cleared", w, 32'h0010_0012);
    rd(4'd1, w); rd(4'd4, w);
    chk("R5 cleared via reads", status_o, 32'h0);

    // R6 load and read together
    load(4'd6, 12'h456, 1'b0);
    load_and_read(4'd6, 12'h789, w);
    chk("R6 read returns old", w, 32'h0002_0456);
    chk("R6 status after collision", status_o, 32'h0040_0040);
    rd(4'd6, w);
    chk("R6 new word kept", w, 32'h0003_0789);
    load_and_read(4'd6, 12'h0AB, w);
    chk("R6 read of empty slot", w, 32'h0000_0789);
    chk("R6 no ovr when unread clear", status_o, 32'h0000_0040);
    rd(4'd6, w);

    // R8 DMA
    dma_en = 1'b1;
    load(4'd7, 12'h0F0, 1'b0);
    chk("R8 dma_req pulse", {31'd0, dma_req}, 32'h1);
    chk("R8 dma_data", {14'd0, dma_data}, 32'h0002_00F0);
    @(negedge clk);
    chk("R8 dma_req one cycle", {31'd0, dma_req}, 32'h0);
    rd(4'd15, w);
    chk("R8 mirror read", w, 32'h0002_00F0);
    load(4'd7, 12'h0F1, 1'b0);
    chk("R8 dma_data ovr", {14'd0, dma_data}, 32'h0003_00F1);
    rd(4'd7, w);

    // R10 out-of-range slot with DMA on
    load(4'd14, 12'h555, 1'b0);
    chk("R10 no req", {31'd0, dma_req}, 32'h0);
    load(4'd15, 12'h666, 1'b1);
    chk("R10 status unchanged", status_o, 32'h0);
    chk("R10 mirror unchanged", {14'd0, dma_data}, 32'h0003_00F1);

    // R9 DMA off
    dma_en = 1'b0;
    load(4'd8, 12'h333, 1'b0);
    chk("R9 no req", {31'd0, dma_req}, 32'h0);
    chk("R9 mirror held", {14'd0, dma_data}, 32'h0003_00F1);
    rd(4'd8, w);
    chk("R1 slot 8", w, 32'h0002_0333);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule